// File: doc/BRIEF.md
# Age-Counter LRU Way Tracker

This block tracks recency for one four-way cache set. Each way has a small age counter and a valid flag. The cache controller reports one event per cycle: a fill, a hit or a replacement, together with the way it concerns. The tracker updates every age in that same cycle. It always presents the way the controller should use for the next miss.

A way that has never been loaded is always offered first. Once every way holds data, the way with the largest age is offered. The ages of the valid ways always form a permutation of 0 up to the valid count minus one. Because of this, no counter ever saturates or wraps.

A mode input switches hit handling off. With hits ignored, ages change only when a way is loaded, so the offered way is the one that was loaded first. To cover several sets, the controller keeps one copy of this state per set and selects it with the set index. Tag compare and data movement are handled elsewhere.

Top module: `lru_age_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every way becomes invalid and every age becomes 0. After that edge, `victim_way` is 0 and `victim_free` is 1.
- R2: A load (`ev_kind` 2'b01 for fill or 2'b11 for replace) to an invalid way does three things. It makes that way valid with age 0. It increments the age of every other valid way by one. It leaves the ages of invalid ways at 0.
- R3: A load to a valid way sets that way's age to 0. It increments every valid way whose age was below the loaded way's previous age. It leaves all other ages unchanged.
- R4: With `fifo_mode` low, a hit (`ev_kind` 2'b10) on a valid way increments every valid way younger than the hit way. It leaves older ways unchanged and sets the hit way's age to 0.
- R5: With `fifo_mode` high, a hit changes no age and no valid flag.
- R6: A cycle with `ev_kind` 2'b00 changes nothing. A hit on an invalid way also changes nothing.
- R7: If any way is invalid, `victim_way` is the lowest-numbered invalid way and `victim_free` is 1. Otherwise `victim_way` is the way with the largest age and `victim_free` is 0.
- R8: The ages of the valid ways are always distinct, and each is below the number of valid ways.
- R9: From reset, three loads give ages (2,1,0,–) for ways 0..3. A fill of way 3 then gives (3,2,1,0). A hit on way 1 then gives (3,0,2,1). Replacing way 0 then gives (0,1,3,2). `age_vec` holds way i at bits [2i+1:2i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1: hits leave ages untouched |
| ev_kind | input | 2 | 00 none, 01 fill, 10 hit, 11 replace |
| ev_way | input | 2 | Way the event refers to |
| age_vec | output | 8 | Age of way i at bits [2i+1:2i] |
| valid_vec | output | 4 | Valid flag per way |
| victim_way | output | 2 | Way to use on the next miss |
| victim_free | output | 1 | Victim way is currently invalid |

## Verification
The hardest states to reach are those where a valid way is reloaded while it is not the oldest. In these states only part of the other ages may move. Reaching them needs a partially filled set or a full set with mixed ages. Mode switches must also fall between reloads and hits.

The stimulus mixes fills aimed at random ways, some of them already valid. It also mixes hits on valid and invalid ways, and replacements of both the offered way and arbitrary ways. It flips `fifo_mode` in phases and resets the set mid-run, so the sequence restarts from partly filled states.

// File: rtl/lru_pkg.sv
// Shared event encoding for the LRU age tracker.
// Assumes a two-bit event code presented once per cycle.
package lru_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'b00,
        EV_FILL = 2'b01,
        EV_HIT  = 2'b10,
        EV_REPL = 2'b11
    } lru_ev_e;
endpackage

// File: rtl/lru_age_next.sv
// Next-state logic for the per-way ages and valid flags.
// Loads and ordered hits share one rule: the target way drops to age 0,
// and only valid ways younger than the target's old age move up by one.
// If the target way is invalid, every valid way moves up instead.
// Assumes the ages of the valid ways form a permutation of 0..count-1.
module lru_age_next #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [NUM_WAYS*AGE_W-1:0] age_q,
    input  logic [NUM_WAYS-1:0]       valid_q,
    input  logic [1:0]                ev_kind,
    input  logic [WAY_W-1:0]          ev_way,
    input  logic                      fifo_mode,
    output logic [NUM_WAYS*AGE_W-1:0] age_d,
    output logic [NUM_WAYS-1:0]       valid_d
);
    import lru_pkg::*;

    logic             is_load;
    logic             tgt_valid;
    logic [AGE_W-1:0] tgt_age;
    logic             apply_order;

    // Decode the event and fetch the target way's current state.
    always_comb begin
        is_load     = (ev_kind == EV_FILL) || (ev_kind == EV_REPL);
        tgt_valid   = valid_q[ev_way];
        tgt_age     = age_q[ev_way*AGE_W +: AGE_W];
        apply_order = is_load || ((ev_kind == EV_HIT) && tgt_valid && !fifo_mode);
    end

    for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
        logic [AGE_W-1:0] age_i;
        logic             is_tgt;
        logic             bump;
        assign age_i  = age_q[i*AGE_W +: AGE_W];
        assign is_tgt = (ev_way == WAY_W'(i));
        assign bump   = apply_order && valid_q[i] && !is_tgt &&
                        (!tgt_valid || (age_i < tgt_age));
        assign age_d[i*AGE_W +: AGE_W] = (apply_order && is_tgt) ? '0 :
                                         bump ? age_i + 1'b1 : age_i;
        assign valid_d[i] = valid_q[i] | (is_load & is_tgt);
    end
endmodule

// File: rtl/lru_victim_pick.sv
// Chooses the way for the next miss.
// The lowest-numbered invalid way wins. With no invalid way, the way
// holding the largest age wins, and ties go to the lower index.
// Assumes the ages are meaningful only for valid ways.
module lru_victim_pick #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [NUM_WAYS*AGE_W-1:0] age_q,
    input  logic [NUM_WAYS-1:0]       valid_q,
    output logic [WAY_W-1:0]          victim_way,
    output logic                      victim_free
);
    logic [WAY_W-1:0] free_idx;
    logic [WAY_W-1:0] old_idx;

    // Scan for the lowest invalid way and for the oldest way.
    always_comb begin
        victim_free = 1'b0;
        free_idx    = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                victim_free = 1'b1;
                free_idx    = WAY_W'(i);
            end
        end
        old_idx = '0;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (age_q[i*AGE_W +: AGE_W] > age_q[old_idx*AGE_W +: AGE_W])
                old_idx = WAY_W'(i);
        end
        victim_way = victim_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/lru_age_tracker.sv
// Recency tracker for one set of NUM_WAYS ways, using one age counter per way.
// It accepts one event per cycle, holds the ages and valid flags, and
// offers the way to use on the next miss.
// Assumes a synchronous active-low reset and a controller that issues
// at most one event per cycle.
module lru_age_tracker #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fifo_mode,
    input  logic [1:0]                ev_kind,
    input  logic [WAY_W-1:0]          ev_way,
    output logic [NUM_WAYS*AGE_W-1:0] age_vec,
    output logic [NUM_WAYS-1:0]       valid_vec,
    output logic [WAY_W-1:0]          victim_way,
    output logic                      victim_free
);
    logic [NUM_WAYS*AGE_W-1:0] age_q, age_d;
    logic [NUM_WAYS-1:0]       valid_q, valid_d;

    lru_age_next #(.NUM_WAYS(NUM_WAYS)) u_next (
        .age_q     (age_q),
        .valid_q   (valid_q),
        .ev_kind   (ev_kind),
        .ev_way    (ev_way),
        .fifo_mode (fifo_mode),
        .age_d     (age_d),
        .valid_d   (valid_d)
    );

    lru_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .age_q       (age_q),
        .valid_q     (valid_q),
        .victim_way  (victim_way),
        .victim_free (victim_free)
    );

    // Hold the ages and valid flags; reset empties the set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q   <= '0;
            valid_q <= '0;
        end else begin
            age_q   <= age_d;
            valid_q <= valid_d;
        end
    end

    assign age_vec   = age_q;
    assign valid_vec = valid_q;
endmodule

// File: rtl/lru_age_tracker_chk.sv
// Property checker for lru_age_tracker, attached with bind.
// Observes only the ports; it drives nothing.
module lru_age_tracker_chk #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int AGE_W = WAY_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fifo_mode,
    input logic [1:0]                ev_kind,
    input logic [WAY_W-1:0]          ev_way,
    input logic [NUM_WAYS*AGE_W-1:0] age_vec,
    input logic [NUM_WAYS-1:0]       valid_vec,
    input logic [WAY_W-1:0]          victim_way,
    input logic                      victim_free
);
    import lru_pkg::*;

    function automatic logic [AGE_W-1:0] age_at(input logic [NUM_WAYS*AGE_W-1:0] v,
                                                input logic [WAY_W-1:0] w);
        return v[w*AGE_W +: AGE_W];
    endfunction

    logic [WAY_W-1:0] last_way;
    logic             perm_bad;

    // Remember the way of the previous event.
    always_ff @(posedge clk) last_way <= ev_way;

    // Flag duplicate or out-of-range ages among the valid ways.
    always_comb begin
        int vcnt;
        vcnt     = 0;
        perm_bad = 1'b0;
        for (int i = 0; i < NUM_WAYS; i++) if (valid_vec[i]) vcnt++;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (valid_vec[i] && int'(age_vec[i*AGE_W +: AGE_W]) >= vcnt) perm_bad = 1'b1;
            for (int j = i + 1; j < NUM_WAYS; j++)
                if (valid_vec[i] && valid_vec[j] &&
                    age_vec[i*AGE_W +: AGE_W] == age_vec[j*AGE_W +: AGE_W])
                    perm_bad = 1'b1;
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0) && (age_vec == '0));

    assert_load_young_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_kind == EV_FILL) || (ev_kind == EV_REPL)) |=>
            valid_vec[last_way] && (age_at(age_vec, last_way) == '0));

    assert_hit_young_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_kind == EV_HIT) && !fifo_mode && valid_vec[ev_way]) |=>
            (age_at(age_vec, last_way) == '0));

    assert_fifo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_kind == EV_HIT) && fifo_mode) |=> $stable(age_vec) && $stable(valid_vec));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_kind == EV_NONE) || ((ev_kind == EV_HIT) && !valid_vec[ev_way])) |=>
            $stable(age_vec) && $stable(valid_vec));

    assert_victim_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec != '1) |-> victim_free && !valid_vec[victim_way]);

    assert_victim_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec == '1) |-> !victim_free &&
            (age_at(age_vec, victim_way) == AGE_W'(NUM_WAYS - 1)));

    assert_age_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !perm_bad);
endmodule

bind lru_age_tracker lru_age_tracker_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_mode   (fifo_mode),
    .ev_kind     (ev_kind),
    .ev_way      (ev_way),
    .age_vec     (age_vec),
    .valid_vec   (valid_vec),
    .victim_way  (victim_way),
    .victim_free (victim_free)
);

// File: tb/lru_age_tracker_tb.sv
`timescale 1ns/1ps
// Bench: a recency queue serves as the reference model and is compared after every clock.
module lru_age_tracker_tb;
    localparam int NW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0;
    logic [1:0] ev_kind = 2'b00;
    logic [1:0] ev_way = 2'b00;
    logic [7:0] age_vec;
    logic [3:0] valid_vec;
    logic [1:0] victim_way;
    logic       victim_free;

    int total = 0;
    int bad = 0;
    int order[$];   // front = most recent valid way

    always #10 clk = ~clk;

    lru_age_tracker #(.NUM_WAYS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ev_kind(ev_kind),
        .ev_way(ev_way), .age_vec(age_vec), .valid_vec(valid_vec),
        .victim_way(victim_way), .victim_free(victim_free)
    );

    function automatic int find_way(int w);
        foreach (order[k]) if (order[k] == w) return k;
        return -1;
    endfunction

    function automatic logic [7:0] exp_ages();
        logic [7:0] v = '0;
        foreach (order[k]) v[order[k]*2 +: 2] = 2'(k);
        return v;
    endfunction

    function automatic logic [3:0] exp_valid();
        logic [3:0] v = '0;
        foreach (order[k]) v[order[k]] = 1'b1;
        return v;
    endfunction

    function automatic int exp_victim();
        for (int w = 0; w < NW; w++) if (find_way(w) < 0) return w;
        return order[order.size() - 1];
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "ages", age_vec, exp_ages());
        chk(tag, "valid", valid_vec, exp_valid());
        chk("R7", "victim", victim_way, exp_victim());
        chk("R7", "victim_free", victim_free, order.size() < NW);
    endtask

    // Called at a negedge: drive, clock, update model, compare at the next negedge.
    task automatic do_ev(logic [1:0] k, int w, logic fm);
        string tag;
        int pos;
        pos = find_way(w);
        if (k == 2'b01 || k == 2'b11) tag = (pos < 0) ? "R2" : "R3";
        else if (k == 2'b10) tag = (pos < 0) ? "R6" : (fm ? "R5" : "R4");
        else tag = "R6";
        ev_kind = k; ev_way = 2'(w); fifo_mode = fm;
        @(posedge clk);
        if (k == 2'b01 || k == 2'b11 || (k == 2'b10 && pos >= 0 && !fm)) begin
            if (pos >= 0) order.delete(pos);
            order.push_front(w);
        end
        @(negedge clk);
        ev_kind = 2'b00;
        compare(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        order.delete();
        compare("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R9 reference sequence
        do_ev(2'b01, 0, 1'b0);
        do_ev(2'b01, 1, 1'b0);
        do_ev(2'b01, 2, 1'b0);
        chk("R9", "three loads", {valid_vec, age_vec}, {4'b0111, 8'h06});
        do_ev(2'b01, 3, 1'b0);
        chk("R9", "fill way3", age_vec, 8'h1B);
        do_ev(2'b10, 1, 1'b0);
        chk("R9", "hit way1", age_vec, 8'h63);
        do_ev(2'b11, 0, 1'b0);
        chk("R9", "replace way0", age_vec, 8'hB4);
        chk("R7", "victim after R9", victim_way, 2);
        // R5: a FIFO-mode hit leaves the ages alone
        do_ev(2'b10, 3, 1'b1);
        chk("R5", "fifo hit", age_vec, 8'hB4);
        // mixed random traffic
        for (int it = 0; it < 3000; it++) begin
            int r, w;
            logic fm;
            fm = ((it / 250) % 2) == 1;
            r = $urandom % 8;
            w = $urandom % NW;
            if (it == 1400) do_reset();
            case (r)
                0:       do_ev(2'b00, w, fm);
                1, 2:    do_ev(2'b01, w, fm);
                3, 4, 5: do_ev(2'b10, w, fm);
                6:       do_ev(2'b11, exp_victim(), fm);
                default: do_ev(2'b11, w, fm);
            endcase
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule